// File: doc/BRIEF.md
# Transmit PLL Power-Up Sequencer

This controller brings a bonded group of serial transmit channels out of reset after power-up. It keeps the transmit PLL powered off for a minimum settling time, then lets the PLL run and waits for it to report lock. The digital reset of the channels is released only after that. One controller drives every channel of the group, so all of them leave reset on the same clock edge.

The minimum power-off time is set in nanoseconds together with the control clock frequency in kilohertz. The block turns these two values into a cycle count and rounds up, so the interval is never shorter than requested. The lock input may change at any time relative to the clock. It passes through a two-stage synchronizer before the sequencer acts on it.

If lock is lost once the channels are running, the digital reset is raised again and the sequencer waits for lock once more. The PLL stays powered in that case.

Top module: `txrst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `pll_pwr_off`=1, every bit of `chan_hold_rst`=1 and `tx_ready`=0.
- R2: After `rst` falls, `pll_pwr_off` stays high for exactly HOLD_CYC rising edges. HOLD_CYC = ceil(CLK_KHZ*HOLD_NS/1e6), with a minimum of 1 (20 for 20000 kHz and 1000 ns; 34 for 33333 kHz and 1000 ns).
- R3: `chan_hold_rst` is high in every cycle in which `pll_pwr_off` is high.
- R4: While waiting for lock, if `pll_lock_in` is sampled high at edge n, `chan_hold_rst` is low after edge n+2. This is the two-stage synchronizer delay.
- R5: `chan_hold_rst` falls only when the synchronized lock was high, meaning `pll_lock_in` was high two edges earlier.
- R6: `tx_ready` rises one edge after `chan_hold_rst` falls, provided the synchronized lock is still high. Otherwise `chan_hold_rst` returns high at that edge. `tx_ready` is high only while `chan_hold_rst` is low.
- R7: With `tx_ready` high, if `pll_lock_in` is sampled low at edge n, then after edge n+2 `chan_hold_rst` is high and `tx_ready` is low. The sequencer then waits for lock as in R4.
- R8: Once `pll_pwr_off` has fallen, it does not rise again until `rst` is asserted.
- R9: All NUM_CH bits of `chan_hold_rst` carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock_in | input | 1 | PLL lock indication, asynchronous |
| pll_pwr_off | output | 1 | Holds the transmit PLL powered off when high |
| chan_hold_rst | output | NUM_CH | Digital reset, one bit per channel, all equal |
| tx_ready | output | 1 | Channels may send data |

## Verification
The bench builds two instances side by side. One uses 20000 kHz with a 1000 ns hold, giving an exact 20-cycle count. The other uses 33333 kHz with 1000 ns, where the product is not a whole number of cycles, so the round-up to 34 cycles becomes observable. Both have four channels. Short power-off counts keep many reset episodes within the run. That brings single-cycle lock glitches, lock arriving during or after the power-off window, and lock loss right after release or deep in the running state within reach.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

    typedef enum logic [1:0] {
        ST_PWR_OFF  = 2'd0,
        ST_AWAIT    = 2'd1,
        ST_RELEASE  = 2'd2,
        ST_LIVE     = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic pwr_off;
        logic hold_rst;
        logic ready;
    } seq_out_t;

    // Cycles needed to cover ns nanoseconds at khz kilohertz, rounded up, at least one.
    function automatic int unsigned hold_cycles(input int unsigned khz, input int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(khz) * longint'(ns);
        cyc  = (prod + 64'd999999) / 64'd1000000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/txrst_sync.sv
module txrst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/txrst_timer.sv
module txrst_timer #(
    parameter int unsigned HOLD_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/txrst_fsm.sv
module txrst_fsm
    import txrst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lock_s,
    input  logic     hold_done,
    output logic     timer_run,
    output seq_out_t outs
);
    seq_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_PWR_OFF: if (hold_done) nxt = ST_AWAIT;
            ST_AWAIT:   if (lock_s)    nxt = ST_RELEASE;
            ST_RELEASE: nxt = lock_s ? ST_LIVE : ST_AWAIT;
            ST_LIVE:    if (!lock_s)   nxt = ST_AWAIT;
            default:    nxt = ST_PWR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PWR_OFF;
        else     state <= nxt;
    end

    assign timer_run     = (state == ST_PWR_OFF);
    assign outs.pwr_off  = (state == ST_PWR_OFF);
    assign outs.hold_rst = (state == ST_PWR_OFF) || (state == ST_AWAIT);
    assign outs.ready    = (state == ST_LIVE);

    // R5
    rst_fall_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.hold_rst) |-> $past(lock_s));

    // R7
    lock_loss_reasserts_chk: assert property (@(posedge clk) disable iff (rst)
        (outs.ready && !lock_s) |=> (outs.hold_rst && !outs.ready));

    // R6
    ready_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.ready) |-> $past(!outs.hold_rst));

    // R8
    no_power_off_again_chk: assert property (@(posedge clk) disable iff (rst)
        !outs.pwr_off |=> !outs.pwr_off);
endmodule

// File: rtl/txrst_seq.sv
module txrst_seq
    import txrst_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 100000,
    parameter int unsigned HOLD_NS = 1000,
    parameter int unsigned NUM_CH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pll_lock_in,
    output logic              pll_pwr_off,
    output logic [NUM_CH-1:0] chan_hold_rst,
    output logic              tx_ready
);
    localparam int unsigned HOLD_CYC = hold_cycles(CLK_KHZ, HOLD_NS);

    logic     lock_s;
    logic     hold_done;
    logic     timer_run;
    seq_out_t outs;

    txrst_sync #(.STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .din (pll_lock_in), .dout (lock_s)
    );

    txrst_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk (clk), .rst (rst), .run (timer_run), .done (hold_done)
    );

    txrst_fsm u_fsm (
        .clk (clk), .rst (rst), .lock_s (lock_s), .hold_done (hold_done),
        .timer_run (timer_run), .outs (outs)
    );

    assign pll_pwr_off = outs.pwr_off;
    assign tx_ready    = outs.ready;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign chan_hold_rst[g] = outs.hold_rst;
    end

    // Independent age counter for the power-off window check.
    logic [31:0] off_age;
    always_ff @(posedge clk) begin
        if (rst)              off_age <= '0;
        else if (pll_pwr_off) off_age <= off_age + 1'b1;
    end

    // R2
    min_power_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_pwr_off) |-> (off_age >= HOLD_CYC));

    // R3
    rst_during_off_chk: assert property (@(posedge clk) disable iff (rst)
        pll_pwr_off |-> (&chan_hold_rst));

    // R9
    lanes_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (&chan_hold_rst) || !(|chan_hold_rst));
endmodule

// File: tb/tb_txrst_seq.sv
module tb_ref #(
    parameter int unsigned HOLD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    output logic pd,
    output logic drst,
    output logic rdy
);
    logic l1, l2;
    int unsigned age;

    always @(posedge clk) begin
        if (rst) begin
            l1 <= 1'b0; l2 <= 1'b0; age <= 0;
            pd <= 1'b1; drst <= 1'b1; rdy <= 1'b0;
        end else begin
            l1 <= lock;
            l2 <= l1;
            if (pd) begin
                age <= age + 1;
                if (age + 1 >= HOLD) pd <= 1'b0;
            end else if (drst) begin
                if (l2) drst <= 1'b0;
            end else if (!rdy) begin
                if (l2) rdy <= 1'b1;
                else    drst <= 1'b1;
            end else if (!l2) begin
                rdy  <= 1'b0;
                drst <= 1'b1;
            end
        end
    end
endmodule

module tb_txrst_seq;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NCH = 4;

    function automatic int unsigned exp_hold(input int unsigned khz, input int unsigned ns);
        int unsigned whole;
        longint unsigned p;
        p = longint'(khz) * ns;
        whole = int'(p / 1000000);
        if ((p % 1000000) != 0) whole++;
        if (whole == 0) whole = 1;
        return whole;
    endfunction

    localparam int unsigned HA = exp_hold(20000, 1000);
    localparam int unsigned HB = exp_hold(33333, 1000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock = 1'b0;
    logic pd_a, pd_b, rdy_a, rdy_b;
    logic [NCH-1:0] hr_a, hr_b;
    logic epd_a, edr_a, erd_a, epd_b, edr_b, erd_b;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txrst_seq #(.CLK_KHZ(20000), .HOLD_NS(1000), .NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .pll_lock_in(lock),
        .pll_pwr_off(pd_a), .chan_hold_rst(hr_a), .tx_ready(rdy_a));

    txrst_seq #(.CLK_KHZ(33333), .HOLD_NS(1000), .NUM_CH(NCH)) dut_odd (
        .clk(clk), .rst(rst), .pll_lock_in(lock),
        .pll_pwr_off(pd_b), .chan_hold_rst(hr_b), .tx_ready(rdy_b));

    tb_ref #(.HOLD(HA)) ref_a (.clk(clk), .rst(rst), .lock(lock), .pd(epd_a), .drst(edr_a), .rdy(erd_a));
    tb_ref #(.HOLD(HB)) ref_b (.clk(clk), .rst(rst), .lock(lock), .pd(epd_b), .drst(edr_b), .rdy(erd_b));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Compare both instances against the reference models (called at negedge).
    task automatic compare_all();
        check(pd_a == epd_a, "R2/R8 pwr_off A", pd_a, epd_a);
        check(hr_a[0] == edr_a, "R4/R5/R7 hold_rst A", hr_a[0], edr_a);
        check(rdy_a == erd_a, "R6/R7 ready A", rdy_a, erd_a);
        check(pd_b == epd_b, "R2/R8 pwr_off B", pd_b, epd_b);
        check(hr_b[0] == edr_b, "R4/R5/R7 hold_rst B", hr_b[0], edr_b);
        check(rdy_b == erd_b, "R6/R7 ready B", rdy_b, erd_b);
        // R9
        check(hr_a == {NCH{hr_a[0]}} && hr_b == {NCH{hr_b[0]}}, "R9 lanes equal", hr_a, {NCH{hr_a[0]}});
        // R3
        check(!pd_a || hr_a[0], "R3 reset during power-off", hr_a[0], 1);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        // R1
        check(pd_a && pd_b, "R1 reset pwr_off", pd_a, 1);
        check(&hr_a && &hr_b, "R1 reset hold_rst", hr_a, {NCH{1'b1}});
        check(!rdy_a && !rdy_b, "R1 reset ready", rdy_a, 0);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int unsigned wa, wb;
        void'($urandom(32'd5150));
        @(negedge clk);
        do_reset(3);

        // Directed: lock already high; measure power-off width (R2) and release timing (R4, R6).
        lock = 1'b1;
        wa = 0; wb = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pd_a) wa++;
            if (pd_b) wb++;
            compare_all();
        end
        // The first negedge after reset release already follows one edge.
        check(wa + 1 == HA, "R2 hold count A", wa + 1, HA);
        check(wb + 1 == HB, "R2 hold count B", wb + 1, HB);
        check(HB == 34, "R2 round-up value", HB, 34);
        check(rdy_a && !hr_a[0], "R6 running A", rdy_a, 1);

        // Directed: lock loss in running state (R7); power stays on (R8).
        @(negedge clk); lock = 1'b0;
        @(negedge clk); compare_all();
        check(rdy_a == 1'b1, "R7 sync delay 1", rdy_a, 1);
        @(negedge clk); compare_all();
        check(rdy_a == 1'b1, "R7 sync delay 2", rdy_a, 1);
        @(negedge clk); compare_all();
        check(hr_a[0] && !rdy_a, "R7 hold_rst reasserted", hr_a[0], 1);
        check(!pd_a && !pd_b, "R8 power stays on", pd_a, 0);

        // Directed: single-cycle lock glitch while waiting (R5, R6).
        @(negedge clk); lock = 1'b1;
        @(negedge clk); lock = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            compare_all();
        end
        check(hr_a[0] && !rdy_a, "R6 glitch returns to hold", hr_a[0], 1);

        // Random episodes.
        for (int ep = 0; ep < 48; ep++) begin
            int unsigned t_on, drop_pct;
            do_reset(1 + ($urandom % 3));
            t_on = $urandom % 70;
            case (ep % 4)
                0: drop_pct = 0;
                1: drop_pct = 3;
                2: drop_pct = 20;
                default: drop_pct = 50;
            endcase
            for (int c = 0; c < 140; c++) begin
                @(negedge clk);
                compare_all();
                if (c < int'(t_on)) lock = ($urandom % 100) < 5;
                else lock = ($urandom % 100) >= drop_pct;
            end
        end

        summary();
    end
endmodule